// File: doc/BRIEF.md
# Call-Waiting Alert Qualifier

This block decides, during an off-hook call, whether a dual-tone alert reported by an external tone detector is a real call-waiting caller-ID start or a false trigger caused by speech. It watches the detector's logic-level output, measures how long each high pulse lasts with a millisecond timer, and steers the detector between tone-alert mode and FSK energy-detect mode. While it takes a measurement it asks for the local speech path to be muted.

A pulse is accepted only if two conditions hold. First, its length must fall inside a window with a lower and an upper bound. Second, a silent period must follow, checked with the detector in energy-detect mode. When both hold, a one-cycle pulse tells downstream logic that the alert is confirmed. The block then holds the mute and FSK mode until the rest of the transaction reports that it is finished. The pulse-length bounds and the quiet window are stored in millisecond registers that can be written at run time. Their reset values come from one of two timing presets: an integrated handset that can mute at once, or an adjunct box that mutes after a delay.

Top module: `cw_alert_qualifier`

## Requirements
- R1: After reset `muteReq`=0, `fskMode`=0 (tone-alert mode) and `validAlert`=0. With `ADJUNCT_PRESET`=0 the limits reset to: minimum pre-mute time 0 ms, minimum pulse 15 ms, maximum pulse 65 ms, quiet window 50 ms. With `ADJUNCT_PRESET`=1 they reset to 15, 30, 65 and 50 ms.
- R2: A rising edge on `detIn` (after a two-stage synchronizer) starts the timer from zero. `muteReq` rises once the timer has counted at least the pre-mute time while `detIn` is still high. A pre-mute time of 0 mutes at once.
- R3: If `detIn` falls while the timer is below the minimum pulse length, `muteReq` drops, `fskMode` stays 0 and no alert is issued.
- R4: If `detIn` falls with the timer at or above the minimum pulse and below the maximum, `fskMode` goes to 1, `muteReq` stays 1 and the timer restarts from zero.
- R5: If `detIn` is still high when the timer reaches the maximum pulse length, `muteReq` drops. The block then waits for `detIn` to fall and takes no further action until a new rising edge.
- R6: During the quiet window, a high `detIn` before the timer reaches the quiet length clears `muteReq` and `fskMode` and issues no alert.
- R7: When the quiet length is reached with `detIn` low, `validAlert` is high for exactly one clock cycle, and `muteReq` and `fskMode` stay 1.
- R8: After a confirmed alert, `detIn` is ignored and the outputs hold until `txnDone` is asserted, which returns both to 0. In every other state, `txnDone` has no effect.
- R9: A cycle with `cfgWr`=1 loads `cfgData` (in ms) into the limit chosen by `cfgSel`: 0 pre-mute time, 1 minimum pulse, 2 maximum pulse, 3 quiet window. The new value applies from the next measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickMs | input | 1 | One-cycle pulse every millisecond |
| detIn | input | 1 | Asynchronous detector output |
| txnDone | input | 1 | Downstream transaction finished |
| cfgWr | input | 1 | Limit write strobe |
| cfgSel | input | 2 | Limit select (0 pre-mute, 1 min pulse, 2 max pulse, 3 quiet) |
| cfgData | input | TIMER_W | Limit value in ms |
| muteReq | output | 1 | Local speech mute request |
| fskMode | output | 1 | 1 = FSK energy-detect mode, 0 = tone-alert mode |
| validAlert | output | 1 | One-cycle confirmed-alert pulse |

## Verification
The hardest cases to reach are the edges of the pulse-length window and the long-pulse lockout. In each, the detector must stay high for an exact number of millisecond ticks and then fall, or keep rising, across the limit. The bench produces ticks itself, one pulse at a time, so it can hold `detIn` high for exactly 14, 15, 64 or 65 ticks and observe the outcome. The adjunct timings are tested by reprogramming the limits through the write port, without rebuilding the block.

// File: rtl/cwaq_pkg.sv
package cwaq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_PREMUTE   = 3'd1,
    ST_MEASURE   = 3'd2,
    ST_QUIET     = 3'd3,
    ST_CONFIRMED = 3'd4,
    ST_LOCKOUT   = 3'd5
  } qualState_e;

  typedef struct packed {
    logic clrTimer;
  } ctrlStrobes_t;

  typedef struct packed {
    logic detHigh;
    logic detRise;
    logic geT1;
    logic geT3;
    logic geMax;
    logic geQuiet;
  } dpStatus_t;

endpackage

// File: rtl/cwaq_datapath.sv
module cwaq_datapath #(
  parameter int TIMER_W        = 8,
  parameter int SYNC_STAGES    = 2,
  parameter bit ADJUNCT_PRESET = 1'b0
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   tickMs,
  input  logic                   detIn,
  input  logic                   cfgWr,
  input  logic [1:0]             cfgSel,
  input  logic [TIMER_W-1:0]     cfgData,
  input  cwaq_pkg::ctrlStrobes_t strb,
  output cwaq_pkg::dpStatus_t    stat
);
  localparam logic [TIMER_W-1:0] DEF_T1    = ADJUNCT_PRESET ? TIMER_W'(15) : TIMER_W'(0);
  localparam logic [TIMER_W-1:0] DEF_T3    = ADJUNCT_PRESET ? TIMER_W'(30) : TIMER_W'(15);
  localparam logic [TIMER_W-1:0] DEF_MAX   = TIMER_W'(65);
  localparam logic [TIMER_W-1:0] DEF_QUIET = TIMER_W'(50);
  localparam logic [TIMER_W-1:0] CNT_TOP   = {TIMER_W{1'b1}};

  // synchronizer chain
  logic [SYNC_STAGES-1:0] syncQ;
  logic detS, detPrevQ;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ <= '0;
        else       syncQ <= detIn;
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], detIn};
    end
  endgenerate

  assign detS = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) detPrevQ <= 1'b0;
    else       detPrevQ <= detS;

  // run-time limits
  logic [TIMER_W-1:0] t1Q, t3Q, maxQ, quietQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      t1Q    <= DEF_T1;
      t3Q    <= DEF_T3;
      maxQ   <= DEF_MAX;
      quietQ <= DEF_QUIET;
    end else if (cfgWr) begin
      case (cfgSel)
        2'd0:    t1Q    <= cfgData;
        2'd1:    t3Q    <= cfgData;
        2'd2:    maxQ   <= cfgData;
        default: quietQ <= cfgData;
      endcase
    end
  end

  // millisecond timer, saturating
  logic [TIMER_W-1:0] cntQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           cntQ <= '0;
    else if (strb.clrTimer)              cntQ <= '0;
    else if (tickMs && cntQ != CNT_TOP)  cntQ <= cntQ + 1'b1;
  end

  always_comb begin
    stat.detHigh = detS;
    stat.detRise = detS && !detPrevQ;
    stat.geT1    = cntQ >= t1Q;
    stat.geT3    = cntQ >= t3Q;
    stat.geMax   = cntQ >= maxQ;
    stat.geQuiet = cntQ >= quietQ;
  end

  AST_TIMER_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!tickMs && !strb.clrTimer) |=> $stable(cntQ)); // R2

  AST_TIMER_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrTimer |=> (cntQ == '0)); // R4

endmodule

// File: rtl/cwaq_control.sv
module cwaq_control (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   txnDone,
  input  cwaq_pkg::dpStatus_t    stat,
  output cwaq_pkg::ctrlStrobes_t strb,
  output logic                   muteReq,
  output logic                   fskMode,
  output logic                   validAlert
);
  import cwaq_pkg::*;

  qualState_e stQ, stNxt;
  logic muteQ, fskQ, validQ;

  always_comb begin
    stNxt         = stQ;
    strb.clrTimer = 1'b0;
    case (stQ)
      ST_IDLE: begin
        strb.clrTimer = 1'b1;
        if (stat.detRise) stNxt = ST_PREMUTE;
      end
      ST_PREMUTE: begin
        if (!stat.detHigh)  stNxt = ST_IDLE;
        else if (stat.geT1) stNxt = ST_MEASURE;
      end
      ST_MEASURE: begin
        if (!stat.detHigh) begin
          if (stat.geT3) begin
            stNxt         = ST_QUIET;
            strb.clrTimer = 1'b1;
          end else begin
            stNxt = ST_IDLE;
          end
        end else if (stat.geMax) begin
          stNxt = ST_LOCKOUT;
        end
      end
      ST_QUIET: begin
        if (stat.detHigh)      stNxt = ST_IDLE;
        else if (stat.geQuiet) stNxt = ST_CONFIRMED;
      end
      ST_CONFIRMED: begin
        strb.clrTimer = 1'b1;
        if (txnDone) stNxt = ST_IDLE;
      end
      ST_LOCKOUT: begin
        if (!stat.detHigh) stNxt = ST_IDLE;
      end
      default: stNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stQ    <= ST_IDLE;
      muteQ  <= 1'b0;
      fskQ   <= 1'b0;
      validQ <= 1'b0;
    end else begin
      stQ    <= stNxt;
      muteQ  <= (stNxt == ST_MEASURE) || (stNxt == ST_QUIET) || (stNxt == ST_CONFIRMED);
      fskQ   <= (stNxt == ST_QUIET) || (stNxt == ST_CONFIRMED);
      validQ <= (stQ == ST_QUIET) && (stNxt == ST_CONFIRMED);
    end
  end

  assign muteReq    = muteQ;
  assign fskMode    = fskQ;
  assign validAlert = validQ;

  AST_MUTE_GATE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(muteQ) |-> ($past(stat.geT1) && $past(stat.detHigh))); // R2

  AST_SHORT_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(muteQ) && !$past(fskQ) && !$past(stat.detHigh)) |-> !$past(stat.geT3)); // R3

  AST_FSK_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fskQ) |-> ($past(stat.geT3) && !$past(stat.detHigh))); // R4

  AST_LONG_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(muteQ) && !$past(fskQ) && $past(stat.detHigh)) |-> $past(stat.geMax)); // R5

  AST_QUIET_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    $fell(fskQ) |-> ($past(txnDone) || $past(stat.detHigh))); // R6

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    validQ |=> !validQ); // R7

  AST_VALID_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    validQ |-> ($past(stat.geQuiet) && !$past(stat.detHigh))); // R7

  AST_HOLD_CONFIRMED: assert property (@(posedge clk) disable iff (!rstN)
    (stQ == ST_CONFIRMED && !txnDone) |=> (muteQ && fskQ)); // R8

endmodule

// File: rtl/cw_alert_qualifier.sv
module cw_alert_qualifier #(
  parameter int TIMER_W        = 8,
  parameter int SYNC_STAGES    = 2,
  parameter bit ADJUNCT_PRESET = 1'b0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tickMs,
  input  logic               detIn,
  input  logic               txnDone,
  input  logic               cfgWr,
  input  logic [1:0]         cfgSel,
  input  logic [TIMER_W-1:0] cfgData,
  output logic               muteReq,
  output logic               fskMode,
  output logic               validAlert
);
  cwaq_pkg::ctrlStrobes_t strb;
  cwaq_pkg::dpStatus_t    stat;

  cwaq_datapath #(
    .TIMER_W        (TIMER_W),
    .SYNC_STAGES    (SYNC_STAGES),
    .ADJUNCT_PRESET (ADJUNCT_PRESET)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .tickMs  (tickMs),
    .detIn   (detIn),
    .cfgWr   (cfgWr),
    .cfgSel  (cfgSel),
    .cfgData (cfgData),
    .strb    (strb),
    .stat    (stat)
  );

  cwaq_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .txnDone    (txnDone),
    .stat       (stat),
    .strb       (strb),
    .muteReq    (muteReq),
    .fskMode    (fskMode),
    .validAlert (validAlert)
  );

endmodule

// File: tb/tb_cw_alert_qualifier.sv
module tb_cw_alert_qualifier;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickMs = 1'b0, detIn = 1'b0, txnDone = 1'b0, cfgWr = 1'b0;
  logic [1:0] cfgSel = 2'd0;
  logic [7:0] cfgData = 8'd0;
  logic muteReq, fskMode, validAlert;

  int nChecks = 0;
  int nFails = 0;
  int validCnt = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  cw_alert_qualifier dut (
    .clk(clk), .rstN(rstN), .tickMs(tickMs), .detIn(detIn), .txnDone(txnDone),
    .cfgWr(cfgWr), .cfgSel(cfgSel), .cfgData(cfgData),
    .muteReq(muteReq), .fskMode(fskMode), .validAlert(validAlert)
  );

  always @(posedge clk) if (rstN && validAlert) validCnt <= validCnt + 1;

  task automatic chk(input int act, input int exp, input string what);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tickMs = 1'b1;
      @(negedge clk) tickMs = 1'b0;
    end
  endtask

  task automatic setDet(input logic v);
    @(negedge clk) detIn = v;
    settle(6);
  endtask

  task automatic cfgWrite(input logic [1:0] sel, input logic [7:0] val);
    @(negedge clk) begin cfgWr = 1'b1; cfgSel = sel; cfgData = val; end
    @(negedge clk) cfgWr = 1'b0;
  endtask

  task automatic doneTxn;
    @(negedge clk) txnDone = 1'b1;
    @(negedge clk) txnDone = 1'b0;
    settle(3);
  endtask

  task automatic testReset;
    chk(muteReq, 0, "R1 reset mute");
    chk(fskMode, 0, "R1 reset mode");
    chk(validAlert, 0, "R1 reset valid");
    doneTxn;
    chk(muteReq + fskMode, 0, "R8 done ignored when idle");
  endtask

  task automatic testValid;
    int v0 = validCnt;
    setDet(1'b1);
    chk(muteReq, 1, "R2 immediate mute T1=0");
    ticks(20);
    setDet(1'b0);
    chk(fskMode, 1, "R4 fsk after in-window pulse");
    chk(muteReq, 1, "R4 mute held");
    ticks(49);
    settle(3);
    chk(validCnt - v0, 0, "R7 no alert before quiet end");
    ticks(1);
    settle(3);
    chk(validCnt - v0, 1, "R7 single-cycle alert");
    chk(muteReq & fskMode, 1, "R7 mute and fsk held");
    setDet(1'b1);
    ticks(5);
    settle(2);
    chk(muteReq & fskMode, 1, "R8 det ignored after confirm");
    setDet(1'b0);
    doneTxn;
    chk(muteReq + fskMode, 0, "R8 done returns idle");
    chk(validCnt - v0, 1, "R8 no extra alert");
  endtask

  task automatic testT3Edges;
    setDet(1'b1);
    ticks(14);
    setDet(1'b0);
    chk(muteReq, 0, "R3 14ms pulse mute released");
    chk(fskMode, 0, "R3 14ms pulse stays tone mode");
    setDet(1'b1);
    ticks(15);
    setDet(1'b0);
    chk(fskMode, 1, "R4 15ms pulse accepted");
    setDet(1'b1);
    chk(muteReq + fskMode, 0, "R6 speech in quiet aborts");
    setDet(1'b0);
  endtask

  task automatic testLong;
    setDet(1'b1);
    ticks(64);
    settle(3);
    chk(muteReq, 1, "R5 64ms still muted");
    ticks(1);
    settle(3);
    chk(muteReq, 0, "R5 65ms releases mute");
    ticks(10);
    settle(3);
    chk(muteReq + fskMode, 0, "R5 locked out while high");
    setDet(1'b0);
    chk(fskMode, 0, "R5 no fsk after long pulse");
    setDet(1'b1);
    chk(muteReq, 1, "R5 fresh rise restarts");
    setDet(1'b0);
    chk(muteReq, 0, "R3 zero length pulse rejected");
  endtask

  task automatic testAdjunct;
    int v0;
    cfgWrite(2'd0, 8'd15);
    cfgWrite(2'd1, 8'd30);
    cfgWrite(2'd3, 8'd30);
    setDet(1'b1);
    chk(muteReq, 0, "R9 T1=15 no early mute");
    ticks(14);
    settle(3);
    chk(muteReq, 0, "R2 14ms premute");
    ticks(1);
    settle(3);
    chk(muteReq, 1, "R2 mute at T1");
    ticks(10);
    setDet(1'b0);
    chk(muteReq + fskMode, 0, "R9 25ms below new T3");
    setDet(1'b1);
    ticks(30);
    setDet(1'b0);
    chk(fskMode, 1, "R9 30ms accepted");
    v0 = validCnt;
    ticks(29);
    settle(3);
    chk(validCnt - v0, 0, "R9 quiet 30 not yet");
    ticks(1);
    settle(3);
    chk(validCnt - v0, 1, "R9 quiet 30 alert");
    doneTxn;
    chk(muteReq + fskMode, 0, "R8 idle after done");
  endtask

  initial begin
    settle(3);
    rstN = 1'b1;
    settle(2);
    testReset;
    testValid;
    testT3Edges;
    testLong;
    testAdjunct;
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog all requirements actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule